// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupt Flags

This block is a two-port 9-bit word store with one interrupt flag per port, used to pass messages from one port to the other. Each port has its own address, active-low select, active-low output enable, active-low write strobe and a busy input from an external arbiter. The two highest addresses act as mailboxes. The second-to-last word belongs to the left port and the last word belongs to the right port.

A port signals its peer by writing a message into the peer's mailbox. That write sets the peer's interrupt in the same clock edge that stores the word. The peer takes the message by reading its own mailbox with select and output enable both low. That access clears its interrupt. A port that sees busy has its write and any flag change it would cause suppressed. The mailbox words are ordinary storage, so a system that ignores the interrupts can use them as plain memory.

All activity is synchronous to one clock. Read data is registered and appears after the edge that samples the read. The interrupt outputs are active low.

Top module: `dpmem_mailbox`

## Requirements
- R1: After reset both `l_irq_n` and `r_irq_n` are high (inactive) and both read-data outputs are zero.
- R2: A right-port write (`r_cs_n`=0, `r_wr_n`=0, `r_busy`=0) to address DEPTH-2 (0x7FE at the default depth) drives `l_irq_n` low from the next clock edge.
- R3: A left-port write (`l_cs_n`=0, `l_wr_n`=0, `l_busy`=0) to address DEPTH-1 (0x7FF at the default depth) drives `r_irq_n` low from the next clock edge.
- R4: A left-port access to DEPTH-2 with `l_cs_n`=0, `l_oe_n`=0 and `l_busy`=0 returns `l_irq_n` high on the next edge, whatever the level of `l_wr_n`.
- R5: A right-port access to DEPTH-1 with `r_cs_n`=0, `r_oe_n`=0 and `r_busy`=0 returns `r_irq_n` high on the next edge, whatever the level of `r_wr_n`.
- R6: While the accessing port's busy input is high, its write neither stores data nor sets the peer flag, and its mailbox access does not clear its own flag.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (low).
- R8: Every word, mailboxes included, is 9-bit storage. A word written by either port is read back by either port. `*_rdata` shows the addressed word one edge after a read (`cs_n`=0, `wr_n`=1).
- R9: A flag changes only through R2 to R5. Writes to other addresses, a port writing its own mailbox, and mailbox reads with output enable high leave both flags unchanged.
- R10: The mailbox word and the peer flag are both updated by the same clock edge. A read of the word issued right after the setting write returns the new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | AW (11) | Left port word address |
| l_cs_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_busy | input | 1 | Left port busy from the external arbiter, active high |
| l_wdata | input | 9 | Left port write data |
| l_rdata | output | 9 | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_addr | input | AW (11) | Right port word address |
| r_cs_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_busy | input | 1 | Right port busy from the external arbiter, active high |
| r_wdata | input | 9 | Right port write data |
| r_rdata | output | 9 | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions check the flag rules on every cycle:
- a qualified mailbox write always sets the peer flag;
- a qualified owner read clears the flag unless a set lands in the same cycle;
- a busy accessing port leaves the flag unchanged;
- a flag never falls without a qualified peer write in the cycle before.

The stored contents are shown only by the bench's scenarios. These cover mailbox data surviving a busy write and a clear done with the write strobe low that also stores a new word. They also cover read-back of the message on both ports and ordinary addresses that must leave the flags alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  localparam int unsigned WORD_W = 9;

  // Mailbox owned by a side: left owns DEPTH-2, right owns DEPTH-1.
  function automatic int unsigned mbx_index(int unsigned depth, side_e side);
    return depth - 2 + ((side == SIDE_R) ? 1 : 0);
  endfunction

  // Next active-low flag value; a set outranks a clear.
  function automatic logic flag_next_n(logic cur_n, logic set, logic clr);
    if (set)      return 1'b0;
    else if (clr) return 1'b1;
    else          return cur_n;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int unsigned AW       = 11,
  parameter int unsigned OWN_MBX  = 2046,
  parameter int unsigned PEER_MBX = 2047
) (
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          wr_n,
  input  logic          busy,
  output logic          wr_ok,
  output logic          set_peer,
  output logic          clr_own
);
  localparam logic [AW-1:0] OWN_A  = AW'(OWN_MBX);
  localparam logic [AW-1:0] PEER_A = AW'(PEER_MBX);

  logic sel;

  always_comb begin
    sel      = !cs_n && !busy;
    wr_ok    = sel && !wr_n;
    set_peer = wr_ok && (addr == PEER_A);
    clr_own  = sel && !oe_n && (addr == OWN_A);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  import mbx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= flag_next_n(irq_n, set, clr);
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a0_addr,
  input  logic          a0_we,
  input  logic          a0_re,
  input  logic [DW-1:0] a0_wdata,
  output logic [DW-1:0] a0_rdata,
  input  logic [AW-1:0] a1_addr,
  input  logic          a1_we,
  input  logic          a1_re,
  input  logic [DW-1:0] a1_wdata,
  output logic [DW-1:0] a1_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Port 0 is written last and so wins a same-address collision.
  always_ff @(posedge clk) begin
    if (a1_we) mem[a1_addr] <= a1_wdata;
    if (a0_we) mem[a0_addr] <= a0_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a0_rdata <= '0;
      a1_rdata <= '0;
    end else begin
      if (a0_re) a0_rdata <= mem[a0_addr];
      if (a1_re) a1_rdata <= mem[a1_addr];
    end
  end
endmodule

// File: rtl/dpmem_mailbox.sv
module dpmem_mailbox #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_cs_n,
  input  logic          l_oe_n,
  input  logic          l_wr_n,
  input  logic          l_busy,
  input  logic [8:0]    l_wdata,
  output logic [8:0]    l_rdata,
  output logic          l_irq_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_cs_n,
  input  logic          r_oe_n,
  input  logic          r_wr_n,
  input  logic          r_busy,
  input  logic [8:0]    r_wdata,
  output logic [8:0]    r_rdata,
  output logic          r_irq_n
);
  import mbx_pkg::*;

  localparam int unsigned NPORT = 2;

  logic [AW-1:0] p_addr [NPORT];
  logic [NPORT-1:0] p_cs_n, p_oe_n, p_wr_n, p_busy;
  logic [NPORT-1:0] p_wr_ok, p_set_peer, p_clr_own, p_read, p_irq_n;

  always_comb begin
    p_addr[0] = l_addr;  p_addr[1] = r_addr;
    p_cs_n    = {r_cs_n, l_cs_n};
    p_oe_n    = {r_oe_n, l_oe_n};
    p_wr_n    = {r_wr_n, l_wr_n};
    p_busy    = {r_busy, l_busy};
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam side_e OWN  = (p == 0) ? SIDE_L : SIDE_R;
    localparam side_e PEER = (p == 0) ? SIDE_R : SIDE_L;

    mbx_port_decode #(
      .AW       (AW),
      .OWN_MBX  (mbx_index(DEPTH, OWN)),
      .PEER_MBX (mbx_index(DEPTH, PEER))
    ) u_dec (
      .addr     (p_addr[p]),
      .cs_n     (p_cs_n[p]),
      .oe_n     (p_oe_n[p]),
      .wr_n     (p_wr_n[p]),
      .busy     (p_busy[p]),
      .wr_ok    (p_wr_ok[p]),
      .set_peer (p_set_peer[p]),
      .clr_own  (p_clr_own[p])
    );

    assign p_read[p] = !p_cs_n[p] && p_wr_n[p];

    // A port's flag is set by the other port's mailbox write.
    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (p_set_peer[NPORT-1-p]),
      .clr   (p_clr_own[p]),
      .irq_n (p_irq_n[p])
    );
  end

  mbx_store #(.DEPTH(DEPTH), .AW(AW), .DW(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a0_addr  (l_addr),
    .a0_we    (p_wr_ok[0]),
    .a0_re    (p_read[0]),
    .a0_wdata (l_wdata),
    .a0_rdata (l_rdata),
    .a1_addr  (r_addr),
    .a1_we    (p_wr_ok[1]),
    .a1_re    (p_read[1]),
    .a1_wdata (r_wdata),
    .a1_rdata (r_rdata)
  );

  assign l_irq_n = p_irq_n[0];
  assign r_irq_n = p_irq_n[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] l_addr,
  input logic          l_cs_n,
  input logic          l_oe_n,
  input logic          l_wr_n,
  input logic          l_busy,
  input logic          l_irq_n,
  input logic [AW-1:0] r_addr,
  input logic          r_cs_n,
  input logic          r_oe_n,
  input logic          r_wr_n,
  input logic          r_busy,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] LBOX = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RBOX = AW'(DEPTH - 1);

  logic r_posts_l, l_posts_r, l_takes, r_takes;
  assign r_posts_l = !r_cs_n && !r_wr_n && !r_busy && r_addr == LBOX;
  assign l_posts_r = !l_cs_n && !l_wr_n && !l_busy && l_addr == RBOX;
  assign l_takes   = !l_cs_n && !l_oe_n && !l_busy && l_addr == LBOX;
  assign r_takes   = !r_cs_n && !r_oe_n && !r_busy && r_addr == RBOX;

  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    r_posts_l |=> !l_irq_n);  // R2
  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    l_posts_r |=> !r_irq_n);  // R3
  AST_LEFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (l_takes && !r_posts_l) |=> l_irq_n);  // R4
  AST_RIGHT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_takes && !l_posts_r) |=> r_irq_n);  // R5
  AST_LEFT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy && !r_posts_l) |=> $stable(l_irq_n));  // R6
  AST_RIGHT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (r_busy && !l_posts_r) |=> $stable(r_irq_n));  // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (r_posts_l && l_takes) |=> !l_irq_n);  // R7
  AST_LEFT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(r_posts_l));  // R9
  AST_RIGHT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_irq_n) |-> $past(l_posts_r));  // R9
endmodule

bind dpmem_mailbox mbx_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n),
  .l_busy(l_busy), .l_irq_n(l_irq_n),
  .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n),
  .r_busy(r_busy), .r_irq_n(r_irq_n)
);

// File: tb/dpmem_mailbox_tb.sv
module dpmem_mailbox_tb_top;
  localparam int unsigned DEPTH = 2048;
  localparam int unsigned AW    = 11;
  localparam logic [AW-1:0] LBOX = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RBOX = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_cs_n = 1, l_oe_n = 1, l_wr_n = 1, l_busy = 0;
  logic r_cs_n = 1, r_oe_n = 1, r_wr_n = 1, r_busy = 0;
  logic [8:0] l_wdata = '0, r_wdata = '0;
  logic [8:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dpmem_mailbox #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n),
    .l_busy(l_busy), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n),
    .r_busy(r_busy), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_cs_n = 1; l_oe_n = 1; l_wr_n = 1; l_busy = 0;
    r_cs_n = 1; r_oe_n = 1; r_wr_n = 1; r_busy = 0;
  endtask

  // Inputs change after the falling edge; results are sampled 1 ns after the rising edge.
  task automatic step();
    @(posedge clk); #1;
    @(negedge clk); idle();
  endtask

  task automatic lop(logic [AW-1:0] a, logic oe_n, logic wr_n, logic busy, logic [8:0] d);
    l_addr = a; l_cs_n = 0; l_oe_n = oe_n; l_wr_n = wr_n; l_busy = busy; l_wdata = d;
  endtask

  task automatic rop(logic [AW-1:0] a, logic oe_n, logic wr_n, logic busy, logic [8:0] d);
    r_addr = a; r_cs_n = 0; r_oe_n = oe_n; r_wr_n = wr_n; r_busy = busy; r_wdata = d;
  endtask

  task automatic t_reset();
    check("R1 l_irq_n", 9'(l_irq_n), 9'd1);
    check("R1 r_irq_n", 9'(r_irq_n), 9'd1);
    check("R1 l_rdata", l_rdata, 9'h000);
    check("R1 r_rdata", r_rdata, 9'h000);
  endtask

  task automatic t_plain();
    lop(11'd5, 0, 0, 0, 9'h1A5); step();
    check("R9 plain write l_irq_n", 9'(l_irq_n), 9'd1);
    check("R9 plain write r_irq_n", 9'(r_irq_n), 9'd1);
    rop(11'd5, 0, 1, 0, 9'h0); step();
    check("R8 right reads left word", r_rdata, 9'h1A5);
  endtask

  task automatic t_left_mail();
    rop(LBOX, 1, 0, 0, 9'h0C3); step();
    check("R2 left flag set", 9'(l_irq_n), 9'd0);
    rop(RBOX, 1, 0, 0, 9'h011); step();
    check("R9 own mailbox write", 9'(r_irq_n), 9'd1);
    lop(LBOX, 1, 1, 0, 9'h0); step();
    check("R9 oe high keeps flag", 9'(l_irq_n), 9'd0);
    check("R10 message readable", l_rdata, 9'h0C3);
    lop(LBOX, 0, 1, 0, 9'h0); step();
    check("R4 left flag cleared", 9'(l_irq_n), 9'd1);
    check("R8 left mailbox data", l_rdata, 9'h0C3);
  endtask

  task automatic t_right_mail();
    lop(RBOX, 1, 0, 0, 9'h155); step();
    check("R3 right flag set", 9'(r_irq_n), 9'd0);
    rop(RBOX, 0, 1, 0, 9'h0); step();
    check("R10 right reads message", r_rdata, 9'h155);
    check("R5 right flag cleared", 9'(r_irq_n), 9'd1);
    lop(RBOX, 1, 0, 0, 9'h156); step();
    check("R3 right flag set again", 9'(r_irq_n), 9'd0);
    rop(RBOX, 0, 0, 0, 9'h0AA); step();
    check("R5 clear with write strobe low", 9'(r_irq_n), 9'd1);
    lop(RBOX, 1, 1, 0, 9'h0); step();
    check("R8 right wrote own mailbox", l_rdata, 9'h0AA);
  endtask

  task automatic t_busy();
    rop(LBOX, 1, 0, 1, 9'h1FF); step();
    check("R6 busy write no set", 9'(l_irq_n), 9'd1);
    lop(LBOX, 1, 1, 0, 9'h0); step();
    check("R6 busy write no store", l_rdata, 9'h0C3);
    rop(LBOX, 1, 0, 0, 9'h033); step();
    check("R2 set before busy clear", 9'(l_irq_n), 9'd0);
    lop(LBOX, 0, 1, 1, 9'h0); step();
    check("R6 busy blocks clear", 9'(l_irq_n), 9'd0);
    lop(LBOX, 0, 1, 0, 9'h0); step();
    check("R4 clear after busy", 9'(l_irq_n), 9'd1);
    check("R8 new message", l_rdata, 9'h033);
  endtask

  task automatic t_priority();
    rop(LBOX, 1, 0, 0, 9'h0F0);
    lop(LBOX, 0, 1, 0, 9'h0); step();
    check("R7 set beats clear", 9'(l_irq_n), 9'd0);
    lop(LBOX, 0, 1, 0, 9'h0); step();
    check("R4 later clear", 9'(l_irq_n), 9'd1);
    check("R10 message after collision", l_rdata, 9'h0F0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    @(negedge clk);
    t_plain();
    t_left_mail();
    t_right_mail();
    t_busy();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule